// File: doc/BRIEF.md
# Character-Row Video Address Generator

This block holds the three counters that walk a character-based display: a column counter stepping once per character time, a scan-line counter for the lines inside one character row, and a row counter for the rows inside one frame. From them it builds a 14-bit word address, which starts each frame at a programmed start address. Every character row begins at a word address that is the programmed displayed width beyond the start of the row before it. Every scan line inside a row restarts at that row's base.

The word address and the low bits of the scan-line counter are folded into a 16-bit byte address for the video RAM. The two top word bits pick a 16 KB page, the three scan-line bits sit in the middle, and the ten low word bits sit below them. Bit 0 is a byte-phase input, so each word is read as two consecutive bytes. Word bits 11..10 never reach the bus. A word count that runs off the end of the ten-bit offset can therefore move into the next page only when both of those hidden bits are set in the start address, which gives a 32 KB screen. A character-clock enable advances everything. The counters and the address keep running through the border area, because this block does no blanking of its own.

Top module: `crtc_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the column, scan-line and row counters load 0 and the word address `ma` loads `start_addr`.
- R2: On each clock with `char_en` high, the column counter advances by 1, and it returns to 0 after the value `h_total`. With `char_en` low, no counter and no address changes.
- R3: The scan-line counter advances by 1 at each column wrap, and it returns to 0 after the value `scan_max`.
- R4: At a column wrap with the scan-line counter at `scan_max`, the row counter advances by 1, and it returns to 0 after the value `v_total`.
- R5: Within a scan line, `ma` rises by 1 per enabled character. At a column wrap that does not end a row, `ma` returns to the base address of the current row.
- R6: At a column wrap that ends a row but not the frame, the new row base and `ma` become the previous row base plus `h_disp`.
- R7: At a column wrap that ends the last row of a frame, the row base and `ma` reload `start_addr`.
- R8: The byte address `vaddr` is built as follows: bits 15..14 = ma[13:12], bits 13..11 = scan[2:0], bits 10..1 = ma[9:0], and bit 0 = `byte_phase`.
- R9: `ma` is a plain 14-bit count. When start bits 11..10 are not both 1, an offset that passes 0x3FF leaves `vaddr[15:14]` unchanged, so the picture wraps inside its page. With both bits set, the offset moves on into the next page.
- R10: With `h_disp`=40, `scan_max`=7 and 25 or more rows, the first address of row 25 equals the start address plus 1000 words, which is 16000 bytes of displayed picture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_en | input | 1 | Character-clock enable; advances the counters |
| byte_phase | input | 1 | Selects the low or high byte of the current word |
| h_total | input | 8 | Last column value of a scan line |
| h_disp | input | 8 | Words per displayed row; the step between row bases |
| scan_max | input | 5 | Last scan-line value within a row |
| v_total | input | 7 | Last row value of a frame |
| start_addr | input | 14 | Frame start word: bits 13..12 page, 11..10 size, 9..0 offset |
| col | output | 8 | Column counter |
| scan | output | 5 | Scan-line counter (row address) |
| row | output | 7 | Character-row counter |
| ma | output | 14 | Current word address |
| vaddr | output | 16 | Video RAM byte address |

## Verification
The properties take for granted that `h_total`, `scan_max`, `v_total`, `h_disp` and `start_addr` stay fixed between resets, and that the counters never sit above their limits. The frame-reload property also compares `ma` with the start address as it stood one cycle earlier. The bench keeps to these assumptions because it changes the geometry and start registers only while `rst` is high and then releases reset, so every run begins from zeroed counters. The enable is dropped in bursts in the middle of the stream, but the register inputs do not move while the counters run.

// File: rtl/crtc_addr_pkg.sv
package crtc_addr_pkg;
  localparam int MA_W   = 14;
  localparam int VA_W   = 16;
  localparam int OFS_W  = 10;
  localparam int RA_USE = 3;

  typedef logic [MA_W-1:0] word_addr_t;
  typedef logic [VA_W-1:0] byte_addr_t;

  // Place page bits, scan-line bits, offset bits and byte phase on the RAM bus.
  function automatic byte_addr_t map_bus(input logic [1:0] page,
                                         input logic [RA_USE-1:0] line,
                                         input logic [OFS_W-1:0] ofs,
                                         input logic phase);
    return {page, line, ofs, phase};
  endfunction
endpackage

// File: rtl/cag_hcount.sv
module cag_hcount #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [HW-1:0] total,
  output logic [HW-1:0] cnt,
  output logic          wrap
);
  assign wrap = adv && (cnt == total);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (adv)  cnt <= cnt + HW'(1);
  end
endmodule

// File: rtl/cag_vcount.sv
module cag_vcount #(
  parameter int SW = 5,
  parameter int VW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_adv,
  input  logic [SW-1:0] scan_max,
  input  logic [VW-1:0] v_total,
  output logic [SW-1:0] scan,
  output logic [VW-1:0] row,
  output logic          row_end,
  output logic          frame_end
);
  assign row_end   = line_adv && (scan == scan_max);
  assign frame_end = row_end && (row == v_total);

  always_ff @(posedge clk) begin
    if (rst) begin
      scan <= '0;
      row  <= '0;
    end else if (row_end) begin
      scan <= '0;
      row  <= frame_end ? '0 : row + VW'(1);
    end else if (line_adv) begin
      scan <= scan + SW'(1);
    end
  end
endmodule

// File: rtl/cag_maddr.sv
module cag_maddr
  import crtc_addr_pkg::*;
#(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          line_adv,
  input  logic          row_end,
  input  logic          frame_end,
  input  logic [HW-1:0] h_disp,
  input  word_addr_t    start_addr,
  output word_addr_t    ma
);
  word_addr_t row_base;
  word_addr_t next_base;

  assign next_base = row_base + MA_W'(h_disp);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_base <= start_addr;
      ma       <= start_addr;
    end else if (frame_end) begin
      row_base <= start_addr;
      ma       <= start_addr;
    end else if (row_end) begin
      row_base <= next_base;
      ma       <= next_base;
    end else if (line_adv) begin
      ma       <= row_base;
    end else if (adv) begin
      ma       <= ma + MA_W'(1);
    end
  end
endmodule

// File: rtl/crtc_addr_gen.sv
module crtc_addr_gen
  import crtc_addr_pkg::*;
#(
  parameter int HW = 8,
  parameter int SW = 5,
  parameter int VW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            char_en,
  input  logic            byte_phase,
  input  logic [HW-1:0]   h_total,
  input  logic [HW-1:0]   h_disp,
  input  logic [SW-1:0]   scan_max,
  input  logic [VW-1:0]   v_total,
  input  logic [MA_W-1:0] start_addr,
  output logic [HW-1:0]   col,
  output logic [SW-1:0]   scan,
  output logic [VW-1:0]   row,
  output logic [MA_W-1:0] ma,
  output logic [VA_W-1:0] vaddr
);
  logic h_wrap;
  logic row_end;
  logic frame_end;

  cag_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst(rst), .adv(char_en), .total(h_total),
    .cnt(col), .wrap(h_wrap)
  );

  cag_vcount #(.SW(SW), .VW(VW)) u_v (
    .clk(clk), .rst(rst), .line_adv(h_wrap), .scan_max(scan_max),
    .v_total(v_total), .scan(scan), .row(row),
    .row_end(row_end), .frame_end(frame_end)
  );

  cag_maddr #(.HW(HW)) u_ma (
    .clk(clk), .rst(rst), .adv(char_en), .line_adv(h_wrap),
    .row_end(row_end), .frame_end(frame_end), .h_disp(h_disp),
    .start_addr(start_addr), .ma(ma)
  );

  assign vaddr = map_bus(ma[13:12], scan[RA_USE-1:0], ma[OFS_W-1:0], byte_phase);
endmodule

// File: rtl/crtc_addr_gen_chk.sv
module crtc_addr_gen_chk #(
  parameter int HW = 8,
  parameter int SW = 5,
  parameter int VW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          char_en,
  input logic          byte_phase,
  input logic [HW-1:0] h_total,
  input logic [SW-1:0] scan_max,
  input logic [VW-1:0] v_total,
  input logic [13:0]   start_addr,
  input logic [HW-1:0] col,
  input logic [SW-1:0] scan,
  input logic [VW-1:0] row,
  input logic [13:0]   ma,
  input logic [15:0]   vaddr
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (col == '0 && scan == '0 && row == '0));
  // R2
  col_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (char_en && col == h_total) |=> col == '0);
  // R2
  col_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (char_en && col != h_total) |=> col == HW'($past(col) + HW'(1)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !char_en |=> ($stable(col) && $stable(scan) && $stable(row) && $stable(ma)));
  // R3
  scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (char_en && col == h_total && scan == scan_max) |=> scan == '0);
  // R4
  row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (char_en && col == h_total && scan == scan_max && row == v_total) |=> row == '0);
  // R5
  ma_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (char_en && col != h_total) |=> ma == 14'($past(ma) + 14'd1));
  // R7
  frame_load_chk: assert property (@(posedge clk) disable iff (rst)
    (char_en && col == h_total && scan == scan_max && row == v_total)
      |=> ma == $past(start_addr));
  // R8
  bus_map_chk: assert property (@(posedge clk) disable iff (rst)
    (vaddr[0] == byte_phase && vaddr[10:1] == ma[9:0] &&
     vaddr[13:11] == scan[2:0] && vaddr[15:14] == ma[13:12]));
endmodule

bind crtc_addr_gen crtc_addr_gen_chk #(.HW(HW), .SW(SW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .char_en(char_en), .byte_phase(byte_phase),
  .h_total(h_total), .scan_max(scan_max), .v_total(v_total),
  .start_addr(start_addr), .col(col), .scan(scan), .row(row),
  .ma(ma), .vaddr(vaddr)
);

// File: tb/test_crtc_addr_gen.sv
module test_crtc_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        char_en = 1'b0;
  logic        byte_phase = 1'b0;
  logic [7:0]  h_total = 8'd5;
  logic [7:0]  h_disp = 8'd4;
  logic [4:0]  scan_max = 5'd2;
  logic [6:0]  v_total = 7'd3;
  logic [13:0] start_addr = 14'h0000;
  logic [7:0]  col;
  logic [4:0]  scan;
  logic [6:0]  row;
  logic [13:0] ma;
  logic [15:0] vaddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  int unsigned m_col, m_scan, m_row;
  logic [13:0] m_ma, m_base;

  always #2 clk = ~clk;

  crtc_addr_gen i_crtc_addr_gen (
    .clk(clk), .rst(rst), .char_en(char_en), .byte_phase(byte_phase),
    .h_total(h_total), .h_disp(h_disp), .scan_max(scan_max),
    .v_total(v_total), .start_addr(start_addr), .col(col), .scan(scan),
    .row(row), .ma(ma), .vaddr(vaddr)
  );

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vaddr(input logic [13:0] w, input int unsigned s, input logic p);
    logic [2:0] s3;
    s3 = 3'(s);
    return {w[13:12], s3, w[9:0], p};
  endfunction

  // Apply geometry under reset; afterwards we sit at a falling edge.
  task automatic do_reset(input logic [7:0] ht, input logic [7:0] hd, input logic [4:0] sm,
                          input logic [6:0] vt, input logic [13:0] st);
    @(negedge clk);
    rst = 1'b1; char_en = 1'b0;
    h_total = ht; h_disp = hd; scan_max = sm; v_total = vt; start_addr = st;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_col = 0; m_scan = 0; m_row = 0; m_ma = st; m_base = st;
  endtask

  // One clock with a given enable; reference advanced from the requirements.
  task automatic step(input logic en);
    char_en = en;
    @(posedge clk);
    if (en) begin
      if (m_col == h_total) begin
        m_col = 0;
        if (m_scan == scan_max) begin
          m_scan = 0;
          if (m_row == v_total) begin
            m_row = 0; m_base = start_addr;
          end else begin
            m_row++; m_base = m_base + 14'(h_disp);
          end
        end else begin
          m_scan++;
        end
        m_ma = m_base;
      end else begin
        m_col++; m_ma = m_ma + 14'd1;
      end
    end
    @(negedge clk);
  endtask

  task automatic compare_all(input string tag);
    check({tag, " col"}, col, m_col);
    check({tag, " scan"}, scan, m_scan);
    check({tag, " row"}, row, m_row);
    check({tag, " ma"}, ma, m_ma);
  endtask

  task automatic t_reset();
    do_reset(8'd5, 8'd4, 5'd2, 7'd3, 14'h2345);
    check("R1 col", col, 0);
    check("R1 scan", scan, 0);
    check("R1 row", row, 0);
    check("R1 ma", ma, 14'h2345);
  endtask

  task automatic t_hold();
    do_reset(8'd5, 8'd4, 5'd2, 7'd3, 14'h0010);
    step(1); step(1);
    for (int i = 0; i < 4; i++) step(0);
    check("R2 hold col", col, 2);
    check("R2 hold ma", ma, 14'h0012);
    for (int i = 0; i < 4; i++) step(1);
    check("R2 wrap col", col, 0);
    check("R3 scan step", scan, 1);
    check("R5 line restart", ma, 14'h0010);
  endtask

  task automatic t_frame();
    do_reset(8'd5, 8'd4, 5'd2, 7'd3, 14'h0100);
    for (int i = 0; i < 2 * 6 * 3 * 4 + 10; i++) begin
      step((i % 7) != 3);
      compare_all("R2 R3 R4 R5 R6 R7 frame");
    end
    // walk to the end of the last row and confirm the reload
    while (!(m_col == 5 && m_scan == 2 && m_row == 3)) step(1);
    check("R6 last row base", ma, 14'h0100 + 14'd12 + 14'd5);
    step(1);
    check("R4 row wrap", row, 0);
    check("R7 reload", ma, 14'h0100);
  endtask

  task automatic t_map();
    do_reset(8'd9, 8'd6, 5'd7, 7'd4, 14'h2ABC);
    for (int i = 0; i < 23; i++) step(1);
    byte_phase = 1'b0; #1;
    check("R8 vaddr phase0", vaddr, exp_vaddr(m_ma, m_scan, 1'b0));
    byte_phase = 1'b1; #1;
    check("R8 vaddr phase1", vaddr, exp_vaddr(m_ma, m_scan, 1'b1));
    byte_phase = 1'b0;
  endtask

  task automatic t_carry();
    do_reset(8'd20, 8'd10, 5'd1, 7'd1, 14'h03FF);
    check("R9 before wrap", vaddr, 16'h07FE);
    step(1);
    check("R9 no page carry", vaddr, 16'h0000);
    check("R9 ma word", ma, 14'h0400);
    do_reset(8'd20, 8'd10, 5'd1, 7'd1, 14'h0FFF);
    step(1);
    check("R9 32K page carry", vaddr, 16'h4000);
  endtask

  task automatic t_size();
    do_reset(8'd63, 8'd40, 5'd7, 7'd38, 14'h3000);
    while (!(m_row == 25 && m_scan == 0 && m_col == 0)) step(1);
    check("R10 row25 col", col, 0);
    check("R10 row25 ma", ma, 14'h3000 + 14'd1000);
    check("R10 bytes", 2 * (ma - 14'h3000) * 8, 16000);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_frame();
    t_map();
    t_carry();
    t_size();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule